// File: doc/BRIEF.md
# HDLC Transmit Framer with Zero-Bit Insertion

This block turns a byte stream of frames into a serial HDLC bit stream, one bit per cycle in which the line clock enable `bit_en` is high. Each frame goes out as an optional repeated preamble byte, an opening flag, the payload, an optional frame check sequence and a closing flag. A `0` is inserted after every run of five `1`s in the payload and check sequence. Between frames the line carries idle fill, either all ones or repeated flags. If a frame follows the previous one at once, one flag closes the first frame and opens the second.

Bytes arrive on a valid/ready port that carries start-of-frame and end-of-frame markers and a per-frame flag to leave out the check sequence. Back-pressure rules: the producer raises `s_valid` and holds `s_data` and the markers steady until it sees `s_ready` high at a rising clock edge. The block raises `s_ready` for at most one cycle per byte, and only in a cycle with `bit_en` high, except while it is dropping the rest of an aborted frame. While dropping, it accepts every offered byte until one marked end-of-frame. The check sequence can be CRC-16 (CCITT) or CRC-32. An abort request, or a missing byte in the middle of a frame, ends the frame with an abort sequence.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After reset `tx_bit` is 1 and `s_ready` is 0. With no frame pending, the line carries all ones when `cfg_idle_flags`=0 and repeated flags when it is 1.
- R2: Every frame opens and closes with the flag 0x7E, sent LSB first (0,1,1,1,1,1,1,0) and never stuffed. The first payload byte is accepted in the cycle that emits the last bit of the opening flag, and its bit 0 is emitted at the next enabled cycle.
- R3: Payload bytes are sent least significant bit first, with no gap between bytes other than inserted zeros.
- R4: Within the payload and check sequence, a 0 is emitted right after every fifth consecutive 1, including when that 1 is the last bit before a flag or an abort. Preamble, flags, abort and idle fill are never stuffed.
- R5: With `cfg_fcs32`=0 the check sequence is a 16-bit CRC over the payload (polynomial 0x1021 in reflected form, register preset to all ones). It is sent complemented, LSB first (the check value of ASCII "123456789" is 0x906E).
- R6: With `cfg_fcs32`=1 the check sequence is a 32-bit CRC (polynomial 0x04C11DB7 in reflected form, preset to all ones), sent complemented, LSB first (check value 0xCBF43926).
- R7: No check sequence is sent when `cfg_fcs_en`=0, or when `s_nocrc` was 1 together with the frame's first byte. In that case the closing flag follows the payload directly.
- R8: With `cfg_pre_reps`=N>0, a frame started from idle is preceded by N copies of `cfg_pre_byte` (LSB first, unstuffed), then the opening flag. With N=0 no preamble is sent.
- R9: If the next frame's first byte is offered by the end of a closing flag, that flag also opens the next frame. No preamble and no idle fill come between the two frames.
- R10: If `abort_req` is 1 when a payload byte that is not the last has been sent, the block sends any pending stuffed 0, then eight 1s, then idle fill. It accepts and drops the remaining bytes of that frame, up to and including the end-of-frame byte.
- R11: If no byte is offered when a non-last payload byte ends (underrun), the frame is aborted exactly as in R10.
- R12: `s_ready` is high only while `s_valid` is high or while dropping. It is never high while a preamble or a check sequence is being sent.
- R13: In a cycle with `bit_en`=0 no bit is emitted, `tx_bit` holds its value and no byte is accepted outside dropping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Line bit enable; one output bit per enabled cycle |
| s_valid | input | 1 | Byte offered |
| s_ready | output | 1 | Byte accepted at this edge |
| s_data | input | 8 | Payload byte |
| s_sof | input | 1 | Byte is the first of a frame |
| s_eof | input | 1 | Byte is the last of a frame |
| s_nocrc | input | 1 | With the first byte: omit the check sequence for this frame |
| abort_req | input | 1 | Abort the frame at the next payload byte boundary |
| cfg_fcs_en | input | 1 | Append a check sequence to frames |
| cfg_fcs32 | input | 1 | 0: CRC-16, 1: CRC-32 |
| cfg_idle_flags | input | 1 | Idle fill: 0 ones, 1 flags |
| cfg_pre_byte | input | 8 | Preamble pattern |
| cfg_pre_reps | input | PRE_REP_W | Number of preamble copies, 0 for none |
| tx_bit | output | 1 | Serial line bit |

## Verification
The bench builds the block with its defaults: a 4-bit preamble count and a stuffing run of five. It sweeps both CRC widths, both idle fills, zero to two preamble copies and payload lengths of one, two and four bytes, with alternating all-ones bytes so that stuffing falls across byte and field boundaries. Further cases cover check-sequence suppression by configuration and per frame, stuffing right before a closing flag, shared flags between back-to-back frames, abort, underrun with recovery, and a gapped bit enable. The expected bit stream is rebuilt from the frame contents and aligned on the first-byte handshake.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int BYTE_W    = 8;
  localparam int FCS_MAX_W = 32;
  localparam int FCS_KINDS = 2;
  localparam logic [BYTE_W-1:0] FLAG_BYTE = 8'h7E;
  localparam logic [BYTE_W-1:0] ONES_BYTE = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_FLAG, ST_DATA, ST_FCS, ST_ABORT
  } tx_state_e;

  // index 0: 16-bit CCITT, index 1: 32-bit
  function automatic int fcs_width(int kind);
    return (kind == 0) ? 16 : 32;
  endfunction

  // polynomials in reflected (LSB-first) form
  function automatic logic [FCS_MAX_W-1:0] fcs_poly(int kind);
    return (kind == 0) ? 32'h0000_8408 : 32'hEDB8_8320;
  endfunction
endpackage

// File: rtl/hdlc_fcs_engine.sv
module hdlc_fcs_engine
  import hdlc_tx_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter logic [FCS_MAX_W-1:0] POLY_R = 32'h0000_8408
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd,
  input  logic                 restart,
  input  logic [BYTE_W-1:0]    data,
  output logic [FCS_MAX_W-1:0] fcs_o
);
  logic [WIDTH-1:0] rem, nxt;

  // byte update, bits taken LSB first
  always_comb begin
    nxt = restart ? '1 : rem;
    for (int i = 0; i < BYTE_W; i++) begin
      nxt = (nxt >> 1) ^ ({WIDTH{nxt[0] ^ data[i]}} & POLY_R[WIDTH-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   rem <= '1;
    else if (upd) rem <= nxt;
  end

  assign fcs_o = FCS_MAX_W'(~rem);
endmodule

// File: rtl/hdlc_zero_insert.sv
module hdlc_zero_insert #(
  parameter int STUFF_RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic zone,     // current bit belongs to a stuffed field
  input  logic src_bit,
  output logic consume,  // source bit is taken this cycle
  output logic tx_bit
);
  localparam int RUN_W = $clog2(STUFF_RUN + 1);

  logic [RUN_W-1:0] ones;
  logic             stuff_now;

  assign stuff_now = (ones == RUN_W'(STUFF_RUN));
  assign consume   = bit_en && !stuff_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_bit <= 1'b1;
      ones   <= '0;
    end else if (bit_en) begin
      if (stuff_now) begin
        tx_bit <= 1'b0;
        ones   <= '0;
      end else begin
        tx_bit <= src_bit;
        ones   <= (zone && src_bit) ? ones + 1'b1 : '0;
      end
    end
  end
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int PRE_REP_W = 4,
  parameter int STUFF_RUN = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_en,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic [BYTE_W-1:0]    s_data,
  input  logic                 s_sof,
  input  logic                 s_eof,
  input  logic                 s_nocrc,
  input  logic                 abort_req,
  input  logic                 cfg_fcs_en,
  input  logic                 cfg_fcs32,
  input  logic                 cfg_idle_flags,
  input  logic [BYTE_W-1:0]    cfg_pre_byte,
  input  logic [PRE_REP_W-1:0] cfg_pre_reps,
  output logic                 tx_bit
);
  localparam int CNT_W = $clog2(FCS_MAX_W + 1);

  tx_state_e              state;
  logic [FCS_MAX_W-1:0]   sh;
  logic [CNT_W-1:0]       cnt;
  logic [PRE_REP_W-1:0]   pre_left;
  logic                   cur_eof, frame_nocrc, discard;
  logic                   zone, consume, seg_end, take, fcs_on;
  logic [BYTE_W-1:0]      fill_byte;
  logic [FCS_MAX_W-1:0]   fcs_val [FCS_KINDS];

  assign zone      = (state == ST_DATA) || (state == ST_FCS);
  assign seg_end   = consume && (cnt == CNT_W'(1));
  assign fill_byte = cfg_idle_flags ? FLAG_BYTE : ONES_BYTE;
  assign fcs_on    = cfg_fcs_en && !frame_nocrc;
  assign take      = seg_end && s_valid && !discard &&
                     (((state == ST_FLAG) && s_sof) ||
                      ((state == ST_DATA) && !cur_eof && !abort_req));
  assign s_ready   = discard || take;

  for (genvar g = 0; g < FCS_KINDS; g++) begin : g_fcs
    hdlc_fcs_engine #(
      .WIDTH  (fcs_width(g)),
      .POLY_R (fcs_poly(g))
    ) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd     (take),
      .restart (state == ST_FLAG),
      .data    (s_data),
      .fcs_o   (fcs_val[g])
    );
  end

  hdlc_zero_insert #(.STUFF_RUN(STUFF_RUN)) u_stuff (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .zone    (zone),
    .src_bit (sh[0]),
    .consume (consume),
    .tx_bit  (tx_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      sh          <= FCS_MAX_W'(ONES_BYTE);
      cnt         <= CNT_W'(BYTE_W);
      pre_left    <= '0;
      cur_eof     <= 1'b0;
      frame_nocrc <= 1'b0;
      discard     <= 1'b0;
    end else begin
      if (discard && s_valid && s_eof) discard <= 1'b0;
      if (consume) begin
        sh  <= sh >> 1;
        cnt <= cnt - 1'b1;
        if (seg_end) begin
          cnt <= CNT_W'(BYTE_W);
          unique case (state)
            ST_IDLE: begin
              if (s_valid && s_sof && !discard) begin
                if (cfg_pre_reps != '0) begin
                  state    <= ST_PRE;
                  sh       <= FCS_MAX_W'(cfg_pre_byte);
                  pre_left <= cfg_pre_reps - 1'b1;
                end else begin
                  state <= ST_FLAG;
                  sh    <= FCS_MAX_W'(FLAG_BYTE);
                end
              end else begin
                sh <= FCS_MAX_W'(fill_byte);
              end
            end
            ST_PRE: begin
              if (pre_left == '0) begin
                state <= ST_FLAG;
                sh    <= FCS_MAX_W'(FLAG_BYTE);
              end else begin
                sh       <= FCS_MAX_W'(cfg_pre_byte);
                pre_left <= pre_left - 1'b1;
              end
            end
            ST_FLAG: begin
              if (take) begin
                state       <= ST_DATA;
                sh          <= FCS_MAX_W'(s_data);
                cur_eof     <= s_eof;
                frame_nocrc <= s_nocrc;
              end else begin
                state <= ST_IDLE;
                sh    <= FCS_MAX_W'(fill_byte);
              end
            end
            ST_DATA: begin
              if (cur_eof) begin
                if (fcs_on) begin
                  state <= ST_FCS;
                  sh    <= fcs_val[cfg_fcs32];
                  cnt   <= CNT_W'(fcs_width(int'(cfg_fcs32)));
                end else begin
                  state <= ST_FLAG;
                  sh    <= FCS_MAX_W'(FLAG_BYTE);
                end
              end else if (take) begin
                sh      <= FCS_MAX_W'(s_data);
                cur_eof <= s_eof;
              end else begin
                state   <= ST_ABORT;
                sh      <= FCS_MAX_W'(ONES_BYTE);
                discard <= 1'b1;
              end
            end
            ST_FCS: begin
              state <= ST_FLAG;
              sh    <= FCS_MAX_W'(FLAG_BYTE);
            end
            ST_ABORT: begin
              state <= ST_IDLE;
              sh    <= FCS_MAX_W'(fill_byte);
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_tx_checker.sv
module hdlc_tx_checker
  import hdlc_tx_pkg::*;
#(
  parameter int STUFF_RUN = 5
) (
  input logic      clk,
  input logic      rst_n,
  input logic      bit_en,
  input logic      s_valid,
  input logic      s_ready,
  input logic      discard,
  input logic      zone,
  input tx_state_e state,
  input logic      tx_bit
);
  localparam int RUN_W = $clog2(STUFF_RUN + 3);

  logic             em_q, zone_q;
  logic [RUN_W-1:0] run_q;

  // run of ones seen on the line that were emitted inside a stuffed field
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      em_q   <= 1'b0;
      zone_q <= 1'b0;
      run_q  <= '0;
    end else begin
      em_q   <= bit_en;
      zone_q <= zone;
      if (em_q) run_q <= (zone_q && tx_bit) ? run_q + 1'b1 : '0;
    end
  end

  assert_stuff_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_W'(STUFF_RUN));

  assert_ready_needs_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (s_valid || discard));

  assert_no_ready_pre_fcs_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_PRE) || (state == ST_FCS)) |-> !s_ready);

  assert_take_on_enable_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !discard) |-> bit_en);

  assert_hold_when_idle_en_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit));
endmodule

bind hdlc_tx_framer hdlc_tx_checker #(.STUFF_RUN(STUFF_RUN)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bit_en  (bit_en),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .discard (discard),
  .zone    (zone),
  .state   (state),
  .tx_bit  (tx_bit)
);

// File: tb/tb_hdlc_tx_framer.sv
`timescale 1ns/1ps
module tb_hdlc_tx_framer;
  localparam int PRE_REP_W = 4;

  logic clk, rst_n, bit_en, s_valid, s_ready, s_sof, s_eof, s_nocrc, abort_req;
  logic cfg_fcs_en, cfg_fcs32, cfg_idle_flags, tx_bit;
  logic [7:0] s_data, cfg_pre_byte;
  logic [PRE_REP_W-1:0] cfg_pre_reps;

  int checks = 0, failures = 0;
  bit cap[$];
  bit exp_q[$];
  int e_ones, sof_idx, cyc, bad_ready;
  bit mark, en_q, gap_mode;

  hdlc_tx_framer #(.PRE_REP_W(PRE_REP_W)) dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_sof(s_sof), .s_eof(s_eof), .s_nocrc(s_nocrc), .abort_req(abort_req),
    .cfg_fcs_en(cfg_fcs_en), .cfg_fcs32(cfg_fcs32), .cfg_idle_flags(cfg_idle_flags),
    .cfg_pre_byte(cfg_pre_byte), .cfg_pre_reps(cfg_pre_reps), .tx_bit(tx_bit)
  );

  initial begin clk = 1'b0; forever #2.5 clk = ~clk; end

  initial begin
    bit_en = 1'b1;
    forever begin
      @(posedge clk); #1;
      cyc++;
      bit_en = gap_mode ? (cyc % 3 != 2) : 1'b1;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (en_q) cap.push_back(tx_bit);
      en_q = bit_en;
      if (gap_mode && s_ready && !bit_en) bad_ready++;
      if (mark && s_valid && s_ready && s_sof) begin
        sof_idx = cap.size();
        mark = 1'b0;
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
    $finish;
  end

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] fcs_calc(bit [7:0] d[$], bit w32);
    logic [31:0] r = '1;
    logic [31:0] p = w32 ? 32'hEDB88320 : 32'h00008408;
    if (!w32) r = 32'h0000FFFF;
    foreach (d[k])
      for (int i = 0; i < 8; i++) begin
        bit fb = r[0] ^ d[k][i];
        r = r >> 1;
        if (fb) r = r ^ p;
      end
    return w32 ? ~r : {16'h0, ~r[15:0]};
  endfunction

  task automatic push_raw(bit [7:0] b);
    for (int i = 0; i < 8; i++) exp_q.push_back(b[i]);
    e_ones = 0;
  endtask

  task automatic push_stuffed(bit b);
    exp_q.push_back(b);
    e_ones = b ? e_ones + 1 : 0;
    if (e_ones == 5) begin exp_q.push_back(1'b0); e_ones = 0; end
  endtask

  task automatic push_body(bit [7:0] d[$], bit with_fcs, int nsent);
    logic [31:0] c;
    e_ones = 0;
    for (int k = 0; k < nsent; k++)
      for (int i = 0; i < 8; i++) push_stuffed(d[k][i]);
    if (with_fcs) begin
      c = fcs_calc(d, cfg_fcs32);
      for (int i = 0; i < (cfg_fcs32 ? 32 : 16); i++) push_stuffed(c[i]);
    end
  endtask

  task automatic send_byte(bit [7:0] b, bit sof, bit eof, bit nc);
    s_valid = 1'b1; s_data = b; s_sof = sof; s_eof = eof; s_nocrc = nc;
    do @(negedge clk); while (!s_ready);
    @(posedge clk); #1;
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0; s_nocrc = 1'b0;
  endtask

  task automatic send_frame(bit [7:0] d[$], bit nc);
    foreach (d[k]) send_byte(d[k], k == 0, k == d.size() - 1, nc);
  endtask

  // mode 0 normal, 1 abort request, 2 underrun
  task automatic run_case(string req, bit [7:0] d0[$], bit nc0, bit two,
                          bit [7:0] d1[$], bit nc1, int mode);
    int pre_bits = cfg_pre_reps * 8;
    int base, need, t, mism, first;
    exp_q.delete();
    for (int r = 0; r < cfg_pre_reps; r++) push_raw(cfg_pre_byte);
    push_raw(8'h7E);
    if (mode == 0) begin
      push_body(d0, cfg_fcs_en && !nc0, d0.size());
      push_raw(8'h7E);
      if (two) begin
        push_body(d1, cfg_fcs_en && !nc1, d1.size());
        push_raw(8'h7E);
      end
    end else begin
      push_body(d0, 1'b0, 1);
      push_raw(8'hFF);
    end
    push_raw(cfg_idle_flags ? 8'h7E : 8'hFF);

    sof_idx = -1; mark = 1'b1;
    if (mode == 0) begin
      send_frame(d0, nc0);
      if (two) send_frame(d1, nc1);
    end else if (mode == 1) begin
      abort_req = 1'b1;
      send_frame(d0, nc0);
      abort_req = 1'b0;
    end else begin
      send_byte(d0[0], 1'b1, 1'b0, nc0);
      repeat (40) @(posedge clk);
      #1;
      for (int k = 1; k < d0.size(); k++) send_byte(d0[k], 1'b0, k == d0.size() - 1, nc0);
    end

    base = sof_idx - (pre_bits + 7);
    need = base + exp_q.size();
    t = 0;
    while (cap.size() < need && t < 20000) begin @(negedge clk); t++; end
    mism = 0; first = -1;
    foreach (exp_q[i]) begin
      if (base < 0 || base + i >= cap.size() || cap[base + i] != exp_q[i]) begin
        mism++;
        if (first < 0) first = i;
      end
    end
    check(sof_idx >= 0 && mism == 0, req, $sformatf("bit stream mismatches (first at %0d)", first),
          mism, 0);
    repeat (4) @(posedge clk);
    #1;
  endtask

  function automatic void mk(ref bit [7:0] q[$], input int len, input int seed);
    q.delete();
    for (int k = 0; k < len; k++)
      q.push_back((k % 2 == 0) ? (8'hFF ^ 8'(seed & 8'h11)) : 8'(seed * 29 + k * 53 + 7));
  endfunction

  initial begin
    bit [7:0] a[$];
    bit [7:0] b[$];
    bit [7:0] digits[$];
    bit ok;
    rst_n = 1'b0; s_valid = 1'b0; s_data = '0; s_sof = 1'b0; s_eof = 1'b0; s_nocrc = 1'b0;
    abort_req = 1'b0; cfg_fcs_en = 1'b1; cfg_fcs32 = 1'b0; cfg_idle_flags = 1'b0;
    cfg_pre_byte = 8'hA5; cfg_pre_reps = '0; gap_mode = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(tx_bit == 1'b1 && s_ready == 1'b0, "R1", "reset state {tx_bit,s_ready}",
          {tx_bit, s_ready}, 2'b10);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (30) @(posedge clk);
    @(negedge clk);
    ok = (cap.size() >= 16);
    for (int i = 1; i <= 16 && ok; i++) if (cap[cap.size() - i] != 1'b1) ok = 1'b0;
    check(ok, "R1", "idle ones after reset", ok, 1);

    for (int i = 0; i < 9; i++) digits.push_back(8'h31 + 8'(i));
    check(fcs_calc(digits, 1'b0) == 32'h906E, "R5", "bench CRC-16 check value",
          fcs_calc(digits, 1'b0), 32'h906E);
    check(fcs_calc(digits, 1'b1) == 32'hCBF43926, "R6", "bench CRC-32 check value",
          fcs_calc(digits, 1'b1), 32'hCBF43926);

    // sweep: CRC width x idle fill x preamble count x payload length
    for (int w = 0; w < 2; w++)
      for (int f = 0; f < 2; f++)
        for (int r = 0; r < 3; r++)
          for (int l = 0; l < 3; l++) begin
            cfg_fcs32 = w[0]; cfg_idle_flags = f[0]; cfg_pre_reps = PRE_REP_W'(r);
            cfg_pre_byte = 8'(8'h3C + 8'(r * 17));
            mk(a, (l == 2) ? 4 : l + 1, w * 31 + f * 7 + r * 3 + l);
            run_case("R1 R2 R3 R4 R5 R6 R8 sweep", a, 1'b0, 1'b0, b, 1'b0, 0);
          end

    cfg_fcs32 = 1'b0; cfg_idle_flags = 1'b0; cfg_pre_reps = '0;
    // check sequence disabled by configuration
    cfg_fcs_en = 1'b0;
    mk(a, 3, 5);
    run_case("R7 cfg off", a, 1'b0, 1'b0, b, 1'b0, 0);
    cfg_fcs_en = 1'b1;
    // suppressed for one frame
    mk(a, 2, 9);
    run_case("R7 per-frame", a, 1'b1, 1'b0, b, 1'b0, 0);
    // five trailing ones right before the closing flag
    a = '{8'h12, 8'hF8};
    run_case("R4 stuff before flag", a, 1'b1, 1'b0, b, 1'b0, 0);
    // long all-ones run across bytes and into CRC-32
    cfg_fcs32 = 1'b1;
    a = '{8'hFF, 8'hFF, 8'hFF};
    run_case("R4 R6 ones run", a, 1'b0, 1'b0, b, 1'b0, 0);
    // back-to-back frames share a flag, preamble only ahead of the first
    cfg_fcs32 = 1'b0; cfg_pre_reps = PRE_REP_W'(2); cfg_pre_byte = 8'h55;
    mk(a, 2, 3); mk(b, 3, 11);
    run_case("R9 shared flag", a, 1'b0, 1'b1, b, 1'b0, 0);
    cfg_pre_reps = '0; cfg_idle_flags = 1'b1;
    mk(a, 1, 4); mk(b, 2, 6);
    run_case("R9 shared flag no FCS", a, 1'b1, 1'b1, b, 1'b1, 0);
    // abort request, then a clean frame
    cfg_idle_flags = 1'b0;
    a = '{8'h1F, 8'h22, 8'h33};
    run_case("R10 abort", a, 1'b0, 1'b0, b, 1'b0, 1);
    mk(a, 2, 21);
    run_case("R10 recovery", a, 1'b0, 1'b0, b, 1'b0, 0);
    // underrun mid-frame, with flag fill afterwards
    cfg_idle_flags = 1'b1;
    a = '{8'h0F, 8'h44, 8'h55};
    run_case("R11 underrun", a, 1'b0, 1'b0, b, 1'b0, 2);
    mk(a, 3, 13);
    run_case("R11 recovery", a, 1'b0, 1'b0, b, 1'b0, 0);
    // gapped bit enable
    cfg_idle_flags = 1'b0; cfg_fcs32 = 1'b1; cfg_pre_reps = PRE_REP_W'(1);
    gap_mode = 1'b1; bad_ready = 0;
    mk(a, 4, 17);
    run_case("R13 gapped enable", a, 1'b0, 1'b0, b, 1'b0, 0);
    gap_mode = 1'b0;
    check(bad_ready == 0, "R12 R13", "accepts without bit enable", bad_ready, 0);

    summary();
    $finish;
  end
endmodule